// File: doc/BRIEF.md
# Passive Serial Link Byte Monitor

This block listens to one direction of a point-to-point serial processor link through a high-impedance tap and never drives the line. A local sampling clock runs much faster than the link bit rate. The block detects the falling edge that opens each packet and then counts a parameterised number of sample clocks per bit to reach the middle of every later bit. From the bit that follows the start bit it decides whether the packet is a data packet or a short acknowledge packet.

Data packets carry a byte, which is written into one of two capture slots. The host reads a slot through a valid/acknowledge handshake. The slots alternate, and the write slot advances during the stop bit. This lets a packet that follows at once be captured while the host still holds the previous byte. Acknowledge packets are reported as single-cycle events and never become bytes. Framing errors and overruns are recorded in sticky flags.

Line convention: the idle level is high. A data packet is 11 bit periods long: start bit low, type bit high, eight data bits least significant first, stop bit high. An acknowledge is a start bit low followed by a type bit low. The line must then return high for at least one bit period.

Top module: `link_tap_rx`

## Requirements
- R1: A synchronous active-high reset clears `q_valid`, `ack_evt`, `frame_err` and `overrun`, and empties both capture slots.
- R2: A data packet (start 0, type 1, data bits LSB first, stop 1) makes its byte appear on `q` with `q_valid` high within a few cycles after the stop bit, for every one of the 256 byte values.
- R3: Each bit is sampled SPB/2 sample clocks after its nominal start, measured from the detected start edge through a two-flop synchroniser. Decoding is therefore correct whatever the phase of the start edge relative to the clock.
- R4: While `q_valid` is high and `q_ack` is low, `q_valid` stays high and `q` stays unchanged. A cycle with both `q_valid` and `q_ack` high consumes exactly one byte.
- R5: Bytes are presented in arrival order. Two queued bytes are read oldest first.
- R6: A packet whose type bit is 0 produces a one-cycle `ack_evt` pulse and no byte. An acknowledge that arrives while no byte is outstanding is harmless.
- R7: A stop bit sampled low sets the sticky `frame_err` flag and discards the byte. Reception then resumes at the next start edge.
- R8: A data packet that completes while both slots hold unread bytes is dropped and sets the sticky `overrun` flag. The two queued bytes are unaffected.
- R9: A low pulse shorter than half a bit period is not treated as a start bit. It produces no byte, no event and no error.
- R10: The write slot switches during the stop bit, so a data packet whose start bit follows the previous stop bit with no idle gap is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Tapped serial line, asynchronous, idle high |
| q | output | DW | Oldest unread byte |
| q_valid | output | 1 | `q` holds an unread byte |
| q_ack | input | 1 | Host takes the byte in any cycle where `q_valid` is also high |
| ack_evt | output | 1 | One-cycle pulse per acknowledge packet |
| frame_err | output | 1 | Sticky: a stop bit was sampled low |
| overrun | output | 1 | Sticky: a byte was lost because both slots were full |

## Verification
The assertions check the handshake hold rule, the stickiness of both error flags, and the single-cycle width of acknowledge events on every cycle. They also check that a byte becomes valid only as a packet finishes. Only the bench scenarios can show the correct value of each decoded byte across all 256 patterns and start-edge phases. The same holds for arrival order across the two slots, for back-to-back capture with no idle gap, for rejection of short glitches, and for the dropping of a byte on overrun or a bad stop bit.

// File: rtl/link_tap_rx.sv
module link_tap_rx #(
  parameter int SPB = 8,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_i,
  output logic [DW-1:0] q,
  output logic          q_valid,
  input  logic          q_ack,
  output logic          ack_evt,
  output logic          frame_err,
  output logic          overrun
);
  localparam int CW = (SPB > 2) ? $clog2(SPB) : 1;
  localparam int NB = DW + 3;
  localparam int BW = $clog2(NB + 1);
  localparam logic [BW-1:0] LASTB = BW'(NB - 1);
  localparam logic [CW-1:0] HALF0 = CW'(SPB / 2 - 1);
  localparam logic [CW-1:0] FULL0 = CW'(SPB - 1);

  logic          s1, s2, s3;
  logic          busy;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bidx;
  logic [DW-1:0] sh;
  logic [DW-1:0] slot [2];
  logic [1:0]    vld;
  logic          wp, rp;

  wire take = q_valid && q_ack;

  assign q       = slot[rp];
  assign q_valid = vld[rp];

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1;
      busy <= 1'b0; cnt <= '0; bidx <= '0; sh <= '0;
      slot[0] <= '0; slot[1] <= '0;
      vld <= 2'b00; wp <= 1'b0; rp <= 1'b0;
      ack_evt <= 1'b0; frame_err <= 1'b0; overrun <= 1'b0;
    end else begin
      s1 <= line_i;
      s2 <= s1;
      s3 <= s2;
      ack_evt <= 1'b0;
      if (!busy) begin
        if (!s2 && s3) begin
          busy <= 1'b1;
          cnt  <= HALF0;
          bidx <= '0;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        cnt  <= FULL0;
        bidx <= bidx + 1'b1;
        if (bidx == '0) begin
          if (s2) busy <= 1'b0;
        end else if (bidx == BW'(1)) begin
          if (!s2) begin
            busy    <= 1'b0;
            ack_evt <= 1'b1;
          end
        end else if (bidx == LASTB) begin
          busy <= 1'b0;
          if (!s2) frame_err <= 1'b1;
          else if (vld[wp]) overrun <= 1'b1;
          else begin
            slot[wp] <= sh;
            vld[wp]  <= 1'b1;
            wp       <= ~wp;
          end
        end else begin
          sh <= {s2, sh[DW-1:1]};
        end
      end
      if (take) begin
        vld[rp] <= 1'b0;
        rp      <= ~rp;
      end
    end
  end

  // R4
  q_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (q_valid && !q_ack) |=> (q_valid && $stable(q)));

  // R7
  ferr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    frame_err |=> frame_err);

  // R8
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  // R6
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ack_evt |=> !ack_evt);

  // R2
  valid_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(q_valid) |-> ($past(busy) && !busy));
endmodule

// File: tb/link_tap_rx_tb.sv
module link_tap_rx_tb;
  localparam int SPB = 8;
  localparam int DW  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          line_i = 1'b1;
  logic [DW-1:0] q;
  logic          q_valid;
  logic          q_ack = 1'b0;
  logic          ack_evt;
  logic          frame_err;
  logic          overrun;

  int errors = 0;
  int checks = 0;
  int ackcnt = 0;

  always #10 clk = ~clk;

  link_tap_rx #(.SPB(SPB), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .line_i(line_i), .q(q), .q_valid(q_valid),
    .q_ack(q_ack), .ack_evt(ack_evt), .frame_err(frame_err), .overrun(overrun)
  );

  always @(negedge clk) if (!rst && ack_evt) ackcnt++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic bitp(input logic v);
    line_i = v;
    repeat (SPB) @(negedge clk);
  endtask

  task automatic send_data(input logic [7:0] b, input logic stop);
    bitp(1'b0);
    bitp(1'b1);
    for (int i = 0; i < 8; i++) bitp(b[i]);
    bitp(stop);
    line_i = 1'b1;
  endtask

  task automatic send_ack();
    bitp(1'b0);
    bitp(1'b0);
    bitp(1'b1);
  endtask

  task automatic read_byte(input int exp, input string tag);
    chk(q_valid == 1'b1, tag, q_valid, 1);
    chk(q == exp[7:0], tag, q, exp);
    q_ack = 1'b1;
    @(negedge clk);
    q_ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int a0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(q_valid == 1'b0, "R1 q_valid", q_valid, 0);
    chk(frame_err == 1'b0, "R1 frame_err", frame_err, 0);
    chk(overrun == 1'b0, "R1 overrun", overrun, 0);
    chk(ackcnt == 0, "R1 ack_evt", ackcnt, 0);

    // R2 R3 R4: every byte value, start edge at varying phases
    for (int b = 0; b < 256; b++) begin
      repeat ((b % SPB) + 1) @(negedge clk);
      send_data(b[7:0], 1'b1);
      repeat (2) @(negedge clk);
      chk(q_valid == 1'b1, "R2 valid", q_valid, 1);
      chk(q == b[7:0], "R2 R3 byte", q, b);
      repeat (3) @(negedge clk);
      chk(q == b[7:0] && q_valid, "R4 hold", q, b);
      q_ack = 1'b1;
      @(negedge clk);
      q_ack = 1'b0;
      chk(q_valid == 1'b0, "R4 consume", q_valid, 0);
    end
    chk(frame_err == 1'b0, "R2 no frame_err", frame_err, 0);

    // R5 R10 back-to-back with no idle gap
    send_data(8'hA5, 1'b1);
    send_data(8'h3C, 1'b1);
    repeat (2) @(negedge clk);
    read_byte(8'hA5, "R5 R10 first");
    read_byte(8'h3C, "R5 R10 second");
    chk(q_valid == 1'b0, "R5 empty", q_valid, 0);

    // R6 ack between data packets
    a0 = ackcnt;
    send_data(8'h11, 1'b1);
    send_ack();
    send_data(8'h22, 1'b1);
    repeat (2) @(negedge clk);
    chk(ackcnt == a0 + 1, "R6 ack counted", ackcnt, a0 + 1);
    read_byte(8'h11, "R6 byte before ack");
    read_byte(8'h22, "R6 byte after ack");

    // R6 unsolicited ack on empty receiver
    a0 = ackcnt;
    send_ack();
    repeat (2) @(negedge clk);
    chk(ackcnt == a0 + 1, "R6 lone ack", ackcnt, a0 + 1);
    chk(q_valid == 1'b0, "R6 no byte", q_valid, 0);
    chk(frame_err == 1'b0, "R6 no error", frame_err, 0);

    // R9 short glitch
    a0 = ackcnt;
    line_i = 1'b0;
    repeat (SPB / 2 - 2) @(negedge clk);
    line_i = 1'b1;
    repeat (3 * SPB) @(negedge clk);
    chk(q_valid == 1'b0, "R9 glitch byte", q_valid, 0);
    chk(ackcnt == a0, "R9 glitch ack", ackcnt, a0);
    chk(frame_err == 1'b0, "R9 glitch err", frame_err, 0);
    send_data(8'h5A, 1'b1);
    repeat (2) @(negedge clk);
    read_byte(8'h5A, "R9 after glitch");

    // R8 overrun
    chk(overrun == 1'b0, "R8 pre", overrun, 0);
    send_data(8'h01, 1'b1);
    send_data(8'h02, 1'b1);
    send_data(8'h03, 1'b1);
    repeat (2) @(negedge clk);
    chk(overrun == 1'b1, "R8 flag", overrun, 1);
    read_byte(8'h01, "R8 oldest kept");
    read_byte(8'h02, "R8 second kept");
    chk(q_valid == 1'b0, "R8 dropped", q_valid, 0);

    // R7 framing error
    send_data(8'h77, 1'b0);
    bitp(1'b1);
    repeat (2) @(negedge clk);
    chk(frame_err == 1'b1, "R7 flag", frame_err, 1);
    chk(q_valid == 1'b0, "R7 discarded", q_valid, 0);
    send_data(8'h88, 1'b1);
    repeat (2) @(negedge clk);
    read_byte(8'h88, "R7 resume");
    chk(frame_err == 1'b1, "R7 sticky", frame_err, 1);
    chk(overrun == 1'b1, "R8 sticky", overrun, 1);

    // R1 reset again clears flags
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(frame_err == 1'b0 && overrun == 1'b0, "R1 flags cleared", frame_err + overrun, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule